// File: doc/BRIEF.md
# Overlapping 1101 Serial Sequence Detector

This block watches a one-bit serial stream, sampled on each rising clock edge, and flags every place where the bits 1, 1, 0, 1 have just arrived in that order. It is a four-state Mealy machine. The flag is combinational from the stored state and the bit now on the input, so it is high during the same cycle in which the final 1 of the pattern is presented. Matches may overlap. The trailing 1 of a hit can serve as the leading 1 of the next hit.

The state is held in two D flip-flops, and their contents are brought out on an observation port for verification. The state assignment follows a Gray order, so moving to an adjacent state in the walk changes only one bit. Both the state assignment and the next-state and output equations are fixed and form part of the contract. A synchronous, active-high reset returns the machine to its idle state.

Top module: `pat_detect_fsm`

## Requirements
- R1: The state is encoded on `state_obs` as {bit1, bit0}: idle = 2'b00, seen "1" = 2'b01, seen "11" = 2'b11, seen "110" = 2'b10.
- R2: A rising clock edge with `rst_i` high puts `state_obs` at 2'b00, whatever the state and input were.
- R3: While `rst_i` is high, `z_o` is 0 for every state and input.
- R4: From 2'b00, the next state is 2'b00 when the input is 0 and 2'b01 when the input is 1.
- R5: From 2'b01, the next state is 2'b00 when the input is 0 and 2'b11 when the input is 1.
- R6: From 2'b11, the next state is 2'b10 when the input is 0 and 2'b11 when the input is 1.
- R7: From 2'b10, the next state is 2'b00 when the input is 0 and 2'b01 when the input is 1.
- R8: With reset low, `z_o` is 1 exactly when the state is 2'b10 and `x_i` is 1. It is valid in the same cycle as `x_i`.
- R9: Detection overlaps. The input 1,1,0,1,1,0,1 gives pulses on the 4th and 7th bits only.
- R10: On a pseudo-random stream of at least 1000 bits, `z_o` and `state_obs` match a model of the transition table at every bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| x_i | input | 1 | Serial input bit |
| z_o | output | 1 | Match flag, combinational (Mealy) |
| state_obs | output | 2 | Present state {bit1, bit0}, for observation |

## Verification
The block has no parameters, so the bench builds it exactly as it is. The directed tasks reach each of the four states along its shortest path and apply both input values there. This covers every one of the eight transitions and every output combination. One task checks that reset overrides a pending hit in the armed state. Another plays the overlapping seven-bit stream, and a 1200-bit stream from a linear feedback shift register is compared with an independent table model at every bit.

// File: rtl/pat_detect_pkg.sv
package pat_detect_pkg;

    // Gray-ordered state assignment; the equations depend on these codes.
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_ONE  = 2'b01,
        ST_TWO  = 2'b11,
        ST_ARM  = 2'b10
    } det_state_e;

    localparam int STATE_W = $bits(det_state_e);

    typedef struct packed {
        det_state_e state;
    } det_regs_t;

    localparam det_regs_t DET_RESET = '{state: ST_IDLE};

endpackage

// File: rtl/pat_next_state.sv
module pat_next_state
    import pat_detect_pkg::*;
(
    input  det_state_e cur_i,
    input  logic       x_i,
    output det_state_e nxt_o
);
    logic hi_q, lo_q;
    logic hi_d, lo_d;

    always_comb begin
        hi_q = cur_i[1];
        lo_q = cur_i[0];
        // Sum-of-products form of the transition table
        hi_d = (hi_q & lo_q) | (lo_q & x_i);
        lo_d = x_i;
        nxt_o = det_state_e'({hi_d, lo_d});
    end
endmodule

// File: rtl/pat_output.sv
module pat_output
    import pat_detect_pkg::*;
(
    input  det_state_e cur_i,
    input  logic       x_i,
    input  logic       rst_i,
    output logic       z_o
);
    always_comb begin
        // Mealy output: armed state with a 1 arriving; forced low in reset
        z_o = cur_i[1] & ~cur_i[0] & x_i & ~rst_i;
    end
endmodule

// File: rtl/pat_detect_fsm.sv
module pat_detect_fsm
    import pat_detect_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               x_i,
    output logic               z_o,
    output logic [STATE_W-1:0] state_obs
);
    det_regs_t  regs_d, regs_q;
    det_state_e nxt_state;

    pat_next_state u_next (
        .cur_i (regs_q.state),
        .x_i   (x_i),
        .nxt_o (nxt_state)
    );

    pat_output u_out (
        .cur_i (regs_q.state),
        .x_i   (x_i),
        .rst_i (rst_i),
        .z_o   (z_o)
    );

    always_comb begin
        regs_d = regs_q;
        regs_d.state = nxt_state;
        if (rst_i) begin
            regs_d = DET_RESET;
        end
    end

    always_ff @(posedge clk_i) begin
        regs_q <= regs_d;
    end

    assign state_obs = regs_q.state;
endmodule

// File: rtl/pat_detect_fsm_chk.sv
module pat_detect_fsm_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic       x_i,
    input logic       z_o,
    input logic [1:0] state_obs
);
    assert_reset_idle_R2: assert property (@(posedge clk_i)
        rst_i |=> (state_obs == 2'b00));

    assert_z_low_in_reset_R3: assert property (@(posedge clk_i)
        rst_i |-> !z_o);

    assert_idle_stay_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_obs == 2'b00 && !x_i) |=> (state_obs == 2'b00));
    assert_idle_go_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_obs == 2'b00 && x_i) |=> (state_obs == 2'b01));

    assert_one_back_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_obs == 2'b01 && !x_i) |=> (state_obs == 2'b00));
    assert_one_go_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_obs == 2'b01 && x_i) |=> (state_obs == 2'b11));

    assert_two_go_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_obs == 2'b11 && !x_i) |=> (state_obs == 2'b10));
    assert_two_stay_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_obs == 2'b11 && x_i) |=> (state_obs == 2'b11));

    assert_arm_back_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_obs == 2'b10 && !x_i) |=> (state_obs == 2'b00));
    assert_arm_hit_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_obs == 2'b10 && x_i) |=> (state_obs == 2'b01));

    assert_z_only_armed_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        z_o |-> (state_obs == 2'b10 && x_i));
    assert_z_on_hit_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_obs == 2'b10 && x_i) |-> z_o);

    // R9: a hit is never followed by a hit on the very next bit
    assert_no_back_to_back_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        z_o |=> !z_o);
endmodule

bind pat_detect_fsm pat_detect_fsm_chk chk_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .x_i       (x_i),
    .z_o       (z_o),
    .state_obs (state_obs)
);

// File: tb/pat_detect_fsm_tb_top.sv
`timescale 1ns/1ps
module pat_detect_fsm_tb_top;
    localparam logic [1:0] M_IDLE = 2'b00;
    localparam logic [1:0] M_ONE  = 2'b01;
    localparam logic [1:0] M_TWO  = 2'b11;
    localparam logic [1:0] M_ARM  = 2'b10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       x   = 1'b0;
    logic       z;
    logic [1:0] st;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [1:0] mdl = M_IDLE;
    int pulses;

    always #5 clk = ~clk;

    pat_detect_fsm dut_i (
        .clk_i     (clk),
        .rst_i     (rst),
        .x_i       (x),
        .z_o       (z),
        .state_obs (st)
    );

    function automatic logic [1:0] mdl_next(input logic [1:0] s, input logic b);
        case (s)
            M_IDLE:  return b ? M_ONE : M_IDLE;
            M_ONE:   return b ? M_TWO : M_IDLE;
            M_TWO:   return b ? M_TWO : M_ARM;
            default: return b ? M_ONE : M_IDLE;
        endcase
    endfunction

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // One bit: drive at negedge, check Mealy output, clock, check state
    task automatic step(input logic b, input string zreq, input string sreq);
        @(negedge clk);
        x = b;
        #1;
        check(zreq, {1'b0, z}, {1'b0, (mdl == M_ARM) && b});
        if (z) pulses++;
        @(posedge clk);
        mdl = mdl_next(mdl, b);
        #1;
        check(sreq, st, mdl);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        x = 1'b0;
        @(posedge clk);
        #1;
        mdl = M_IDLE;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        // R1/R2: state after reset is idle code 00
        do_reset();
        check("R2", st, 2'b00);
        // walk to armed state, then assert reset with a 1 pending
        step(1'b1, "R8", "R4");
        step(1'b1, "R8", "R5");
        step(1'b0, "R8", "R6");
        check("R1", st, 2'b10);
        @(negedge clk);
        rst = 1'b1;
        x = 1'b1;
        #1;
        check("R3", {1'b0, z}, 2'b00);
        @(posedge clk);
        #1;
        check("R2", st, 2'b00);
        check("R3", {1'b0, z}, 2'b00);
        mdl = M_IDLE;
        @(negedge clk);
        rst = 1'b0;
        x = 1'b0;
    endtask

    task automatic goto(input logic [1:0] tgt);
        do_reset();
        case (tgt)
            M_ONE: step(1'b1, "R8", "R4");
            M_TWO: begin step(1'b1, "R8", "R4"); step(1'b1, "R8", "R5"); end
            M_ARM: begin step(1'b1, "R8", "R4"); step(1'b1, "R8", "R5"); step(1'b0, "R8", "R6"); end
            default: ;
        endcase
        check("R1", st, tgt);
    endtask

    task automatic t_transitions();
        for (int b = 0; b < 2; b++) begin
            goto(M_IDLE); step(b[0], "R8", "R4");
            goto(M_ONE);  step(b[0], "R8", "R5");
            goto(M_TWO);  step(b[0], "R8", "R6");
            goto(M_ARM);  step(b[0], "R8", "R7");
        end
    endtask

    task automatic t_overlap();
        logic [6:0] seq;
        int got;
        seq = 7'b1101101;
        do_reset();
        pulses = 0;
        for (int i = 6; i >= 0; i--) begin
            step(seq[i], "R9", "R9");
        end
        got = pulses;
        check("R9", got[1:0], 2'd2);
    endtask

    task automatic t_random();
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        do_reset();
        for (int i = 0; i < 1200; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0], "R10", "R10");
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        t_reset();
        t_transitions();
        t_overlap();
        t_random();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule